// File: doc/BRIEF.md
# Majority-Vote Event Synchronization Monitor

This block watches a set of parallel hit buses (twelve by default, eight also supported) that all carry the same stream of events. Each event closes with an end-of-event word, and the low bits of that word hold an event tag. When the streams are in step, every bus reports the same tag for a given event. The block catches the tag on each enabled bus. When every enabled bus has delivered its tag, it chooses a reference by majority vote.

The vote compares every pair of enabled buses. Each bus gets an agreement count: the number of other enabled buses that carry the same tag. The block finds the highest count, marks every bus that reaches it as a winner, and reports how many winners there are. The tag of the lowest-numbered winner becomes the reference. A tie flag rises when the winners do not all carry one value.

Every enabled bus whose tag differs from the reference is flagged as out of step. Each bus has its own saturating loss counter and a sticky error flag, and a single flag reports an error on any bus. A per-bus enable mask takes buses out of both the vote and the counting. The block sits beside the data path and only observes it; it does not forward or deserialize data.

Top module: `sync_vote_monitor`

## Requirements
- R1: On an enabled bus, the tag (bits TAG_W-1:0 of that bus's word) is captured only in a cycle where valid and end-of-event are both high. For each event only the first such word per bus counts. Later end-of-event words on that bus, end-of-event without valid, and all words on disabled buses are ignored.
- R2: The vote starts once every enabled bus has a captured tag. `done` pulses high for exactly one cycle, at the fourth rising edge after the edge that captured the last tag.
- R3: `max_agree` equals the highest number, over enabled buses, of other enabled buses that carry the same tag.
- R4: `winners` has bit i set exactly when bus i is enabled and its agreement count equals `max_agree`. `win_count` is the number of set bits in `winners`.
- R5: `ref_tag` equals the tag of the lowest-numbered winning bus.
- R6: `tie` is high exactly when some winning bus carries a tag different from `ref_tag`.
- R7: `mismatch` bit i is set exactly when bus i is enabled and its tag differs from `ref_tag`. Disabled buses are never flagged.
- R8: One cycle after `done`, the loss counter of each flagged bus (field i of `loss_cnt`, bits i*CNT_W +: CNT_W) increases by one. A counter that is already all ones stays there.
- R9: `err_flags` bit i latches when bus i is flagged and stays set. `any_err` is the OR of `err_flags`.
- R10: A synchronous `clr` zeroes every loss counter and every error flag on the next edge.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and error flags |
| bus_en | input | NB | Per-bus enable mask |
| bus_valid | input | NB | Per-bus word valid |
| bus_eoe | input | NB | Per-bus end-of-event marker |
| bus_data | input | NB*WORD_W | Per-bus words, bus i at bits i*WORD_W +: WORD_W |
| ref_tag | output | TAG_W | Voted reference tag |
| mismatch | output | NB | Buses whose tag differs from the reference |
| winners | output | NB | Buses that reach the top agreement count |
| win_count | output | $clog2(NB+1) | Number of winning buses |
| max_agree | output | $clog2(NB+1) | Top agreement count |
| tie | output | 1 | Winners hold more than one distinct value |
| done | output | 1 | One-cycle pulse when the vote results are updated |
| err_flags | output | NB | Sticky per-bus loss flags |
| any_err | output | 1 | OR of all sticky flags |
| loss_cnt | output | NB*CNT_W | Saturating per-bus loss counters |

## Verification
The assertions assume that `bus_en` is not changed while an event is being gathered, and that at least one bus is enabled when the vote starts. The stimulus sets the enable mask before the first word of each event and holds it until `done`. It also keeps each enable mask non-empty. Apart from these limits, the stimulus freely sends duplicate end-of-event words, end-of-event markers without valid, and traffic on disabled buses, because the design must ignore all of them.

// File: rtl/svm_pkg.sv
package svm_pkg;
  // widest bus set the helper functions cover
  localparam int unsigned MAXB = 16;

  function automatic int unsigned ones16(input logic [MAXB-1:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < int'(MAXB); k++) if (v[k]) n = n + 1;
    return n;
  endfunction

  // index of the lowest set bit, MAXB when none is set
  function automatic int unsigned first16(input logic [MAXB-1:0] v);
    int unsigned p;
    p = MAXB;
    for (int k = int'(MAXB) - 1; k >= 0; k--) if (v[k]) p = unsigned'(k);
    return p;
  endfunction
endpackage

// File: rtl/svm_capture.sv
module svm_capture #(
  parameter int unsigned NB     = 12,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned TAG_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NB-1:0]       bus_en,
  input  logic [NB-1:0]       bus_valid,
  input  logic [NB-1:0]       bus_eoe,
  input  logic [NB*WORD_W-1:0] bus_data,
  output logic                launch,
  output logic [NB*TAG_W-1:0] tags
);
  logic [NB-1:0] got;
  logic [NB-1:0] take;
  logic          unused_bits;

  function automatic logic [TAG_W-1:0] tag_of(input logic [WORD_W-1:0] w);
    return w[TAG_W-1:0];
  endfunction

  assign take   = bus_en & bus_valid & bus_eoe & ~got;
  assign launch = (|bus_en) && ((got | ~bus_en) == {NB{1'b1}});
  assign unused_bits = ^bus_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      got <= '0;
    else if (launch) got <= '0;
    else             got <= got | take;
  end

  for (genvar i = 0; i < NB; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tags[i*TAG_W +: TAG_W] <= '0;
      else if (take[i]) tags[i*TAG_W +: TAG_W] <= tag_of(bus_data[i*WORD_W +: WORD_W]);
    end

    // R1
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (got[i] && !launch) |=> $stable(tags[i*TAG_W +: TAG_W]));
  end
endmodule

// File: rtl/svm_vote.sv
module svm_vote #(
  parameter int unsigned NB    = 12,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned CW   = $clog2(NB + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic [NB*TAG_W-1:0] tags_in,
  input  logic [NB-1:0]       en_in,
  output logic                done,
  output logic [TAG_W-1:0]    ref_tag,
  output logic [NB-1:0]       mismatch,
  output logic [NB-1:0]       winners,
  output logic [CW-1:0]       win_count,
  output logic [CW-1:0]       max_agree,
  output logic                tie
);
  typedef logic [CW-1:0] cnt_t;

  function automatic cnt_t agree_of(input logic [NB*TAG_W-1:0] t,
                                    input logic [NB-1:0] e, input int i);
    cnt_t n;
    n = '0;
    for (int j = 0; j < int'(NB); j++)
      if (j != i && e[j] && e[i] && t[j*TAG_W +: TAG_W] == t[i*TAG_W +: TAG_W])
        n = n + cnt_t'(1);
    return n;
  endfunction

  function automatic cnt_t max_of(input logic [NB*CW-1:0] a, input logic [NB-1:0] e);
    cnt_t m;
    m = '0;
    for (int i = 0; i < int'(NB); i++)
      if (e[i] && a[i*CW +: CW] > m) m = a[i*CW +: CW];
    return m;
  endfunction

  // stage 1: snapshot
  logic                s1_v;
  logic [NB*TAG_W-1:0] s1_tag;
  logic [NB-1:0]       s1_en;
  // stage 2: agreement counts
  logic                s2_v;
  logic [NB*TAG_W-1:0] s2_tag;
  logic [NB-1:0]       s2_en;
  logic [NB*CW-1:0]    s2_agree, agree_c;
  // stage 3: maximum and winners
  logic                s3_v;
  logic [NB*TAG_W-1:0] s3_tag;
  logic [NB-1:0]       s3_en, s3_win, win_c;
  cnt_t                s3_max, max_c;
  // stage 4 combinational results
  logic [TAG_W-1:0]    ref_c;
  logic [NB-1:0]       mm_c;

  for (genvar i = 0; i < NB; i++) begin : g_agree
    assign agree_c[i*CW +: CW] = agree_of(s1_tag, s1_en, i);
    assign win_c[i] = s2_en[i] && (s2_agree[i*CW +: CW] == max_c);
  end
  assign max_c = max_of(s2_agree, s2_en);

  always_comb begin
    int unsigned fi;
    fi = svm_pkg::first16(svm_pkg::MAXB'(s3_win));
    if (fi >= NB) fi = 0;
    ref_c = s3_tag[fi*TAG_W +: TAG_W];
    for (int i = 0; i < int'(NB); i++)
      mm_c[i] = s3_en[i] && (s3_tag[i*TAG_W +: TAG_W] != ref_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_tag <= '0; s1_en <= '0;
      s2_v <= 1'b0; s2_tag <= '0; s2_en <= '0; s2_agree <= '0;
      s3_v <= 1'b0; s3_tag <= '0; s3_en <= '0; s3_win <= '0; s3_max <= '0;
      done <= 1'b0; ref_tag <= '0; mismatch <= '0; winners <= '0;
      win_count <= '0; max_agree <= '0; tie <= 1'b0;
    end else begin
      s1_v <= launch;
      if (launch) begin
        s1_tag <= tags_in;
        s1_en  <= en_in;
      end
      s2_v <= s1_v;
      if (s1_v) begin
        s2_tag   <= s1_tag;
        s2_en    <= s1_en;
        s2_agree <= agree_c;
      end
      s3_v <= s2_v;
      if (s2_v) begin
        s3_tag <= s2_tag;
        s3_en  <= s2_en;
        s3_win <= win_c;
        s3_max <= max_c;
      end
      done <= s3_v;
      if (s3_v) begin
        ref_tag   <= ref_c;
        mismatch  <= mm_c;
        winners   <= s3_win;
        win_count <= cnt_t'(svm_pkg::ones16(svm_pkg::MAXB'(s3_win)));
        max_agree <= s3_max;
        tie       <= |(s3_win & mm_c);
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  ref_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && winners != '0) |-> ((mismatch & (winners & (~winners + 1'b1))) == '0));
  // R6
  no_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tie) |-> ((mismatch & winners) == '0));
  // R4
  win_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((winners == '0) == (win_count == '0)));
endmodule

// File: rtl/svm_loss.sv
module svm_loss #(
  parameter int unsigned NB    = 12,
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               done,
  input  logic [NB-1:0]      mismatch,
  output logic [NB-1:0]      err_flags,
  output logic [NB*CNT_W-1:0] loss_cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == TOP) ? c : c + 1'b1;
  endfunction

  for (genvar i = 0; i < NB; i++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        loss_cnt[i*CNT_W +: CNT_W] <= '0;
        err_flags[i] <= 1'b0;
      end else if (clr) begin
        loss_cnt[i*CNT_W +: CNT_W] <= '0;
        err_flags[i] <= 1'b0;
      end else if (done && mismatch[i]) begin
        loss_cnt[i*CNT_W +: CNT_W] <= sat_inc(loss_cnt[i*CNT_W +: CNT_W]);
        err_flags[i] <= 1'b1;
      end
    end

    // R8
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (loss_cnt[i*CNT_W +: CNT_W] == $past(loss_cnt[i*CNT_W +: CNT_W])) ||
               (loss_cnt[i*CNT_W +: CNT_W] == $past(loss_cnt[i*CNT_W +: CNT_W]) + 1'b1));
    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && loss_cnt[i*CNT_W +: CNT_W] == TOP) |=> (loss_cnt[i*CNT_W +: CNT_W] == TOP));
  end

  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (loss_cnt == '0 && err_flags == '0));
endmodule

// File: rtl/sync_vote_monitor.sv
module sync_vote_monitor #(
  parameter int unsigned NB     = 12,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned CW    = $clog2(NB + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [NB-1:0]        bus_en,
  input  logic [NB-1:0]        bus_valid,
  input  logic [NB-1:0]        bus_eoe,
  input  logic [NB*WORD_W-1:0] bus_data,
  output logic [TAG_W-1:0]     ref_tag,
  output logic [NB-1:0]        mismatch,
  output logic [NB-1:0]        winners,
  output logic [CW-1:0]        win_count,
  output logic [CW-1:0]        max_agree,
  output logic                 tie,
  output logic                 done,
  output logic [NB-1:0]        err_flags,
  output logic                 any_err,
  output logic [NB*CNT_W-1:0]  loss_cnt
);
  logic                launch;
  logic [NB*TAG_W-1:0] tags;

  svm_capture #(.NB(NB), .WORD_W(WORD_W), .TAG_W(TAG_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_valid(bus_valid),
    .bus_eoe(bus_eoe), .bus_data(bus_data), .launch(launch), .tags(tags));

  svm_vote #(.NB(NB), .TAG_W(TAG_W)) u_vote (
    .clk(clk), .rst_n(rst_n), .launch(launch), .tags_in(tags), .en_in(bus_en),
    .done(done), .ref_tag(ref_tag), .mismatch(mismatch), .winners(winners),
    .win_count(win_count), .max_agree(max_agree), .tie(tie));

  svm_loss #(.NB(NB), .CNT_W(CNT_W)) u_loss (
    .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .mismatch(mismatch),
    .err_flags(err_flags), .loss_cnt(loss_cnt));

  assign any_err = |err_flags;

  // R9
  any_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mismatch != '0 && !clr) |=> any_err);
endmodule

// File: tb/tb_sync_vote_monitor.sv
module tb_sync_vote_monitor;
  localparam int NB = 12, WW = 16, TW = 8, CN = 3, CW = 4;
  localparam time CLK_P = 10ns;
  localparam int NV = 6;
  localparam logic [7:0] TAB [NV][12] = '{
    '{8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11},
    '{8'h22,8'h22,8'h22,8'h23,8'h22,8'h22,8'h22,8'h99,8'h22,8'h22,8'h22,8'h22},
    '{8'hA0,8'hA0,8'hA0,8'hA0,8'hA0,8'hA0,8'hB0,8'hB0,8'hB0,8'hB0,8'hB0,8'hB0},
    '{8'h01,8'h04,8'h07,8'h0A,8'h0D,8'h10,8'h13,8'h16,8'h19,8'h1C,8'h1F,8'h22},
    '{8'h33,8'h33,8'h33,8'h33,8'h05,8'h06,8'h06,8'h06,8'h33,8'h33,8'h33,8'h33},
    '{8'h01,8'h02,8'h02,8'h03,8'h03,8'h45,8'h46,8'h47,8'h48,8'h49,8'h4A,8'h4B}};
  localparam logic [11:0] ENT [NV] = '{12'hFFF,12'hFFF,12'hFFF,12'hFFF,12'h0F0,12'hFFF};

  logic clk = 0, rst_n = 0, clr = 0;
  logic [NB-1:0] bus_en = '0, bus_valid = '0, bus_eoe = '0;
  logic [NB*WW-1:0] bus_data = '0;
  logic [TW-1:0] ref_tag;
  logic [NB-1:0] mismatch, winners, err_flags;
  logic [CW-1:0] win_count, max_agree;
  logic tie, done, any_err;
  logic [NB*CN-1:0] loss_cnt;

  int n_run = 0, n_fail = 0;
  logic [7:0] cur_tag [12];
  logic [CN-1:0] mcnt [12];
  logic [NB-1:0] merr;
  logic [7:0] e_ref; logic [NB-1:0] e_mm, e_win; int e_wc, e_max; logic e_tie;

  sync_vote_monitor #(.NB(NB), .WORD_W(WW), .TAG_W(TW), .CNT_W(CN)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bus_en(bus_en), .bus_valid(bus_valid),
    .bus_eoe(bus_eoe), .bus_data(bus_data), .ref_tag(ref_tag), .mismatch(mismatch),
    .winners(winners), .win_count(win_count), .max_agree(max_agree), .tie(tie),
    .done(done), .err_flags(err_flags), .any_err(any_err), .loss_cnt(loss_cnt));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected vote: occurrence count of each enabled tag minus itself
  task automatic model(input logic [7:0] t [12], input logic [11:0] en);
    int ag [12];
    int lo;
    e_max = 0; e_win = '0; e_wc = 0; e_mm = '0; e_tie = 0; lo = -1;
    for (int i = 0; i < NB; i++) begin
      ag[i] = 0;
      if (en[i]) begin
        for (int j = 0; j < NB; j++) if (en[j] && t[j] == t[i]) ag[i]++;
        ag[i]--;
        if (ag[i] > e_max) e_max = ag[i];
      end
    end
    for (int i = 0; i < NB; i++)
      if (en[i] && ag[i] == e_max) begin
        e_win[i] = 1'b1; e_wc++;
        if (lo < 0) lo = i;
      end
    e_ref = t[lo];
    for (int i = 0; i < NB; i++) begin
      if (en[i] && t[i] != e_ref) e_mm[i] = 1'b1;
      if (e_win[i] && t[i] != e_ref) e_tie = 1;
    end
  endtask

  task automatic put(input logic [NB-1:0] vm, input logic [NB-1:0] em);
    @(negedge clk);
    for (int i = 0; i < NB; i++) bus_data[i*WW +: WW] = {8'(8'h30 + i), cur_tag[i]};
    bus_valid = vm; bus_eoe = em;
    @(negedge clk);
    bus_valid = '0; bus_eoe = '0;
  endtask

  task automatic check_result(input string tagname);
    check("R5", {tagname, " ref"}, ref_tag, e_ref);
    check("R7", {tagname, " mismatch"}, mismatch, e_mm);
    check("R4", {tagname, " winners"}, winners, e_win);
    check("R4", {tagname, " win_count"}, win_count, e_wc);
    check("R3", {tagname, " max_agree"}, max_agree, e_max);
    check("R6", {tagname, " tie"}, tie, e_tie);
    @(negedge clk);
    check("R2", {tagname, " done one cycle"}, done, 0);
    for (int i = 0; i < NB; i++) if (e_mm[i]) begin
      if (mcnt[i] != '1) mcnt[i] = mcnt[i] + 1'b1;
      merr[i] = 1'b1;
    end
    for (int i = 0; i < NB; i++)
      check("R8", $sformatf("%s loss_cnt[%0d]", tagname, i), loss_cnt[i*CN +: CN], mcnt[i]);
    check("R9", {tagname, " err_flags"}, err_flags, merr);
    check("R9", {tagname, " any_err"}, any_err, |merr);
  endtask

  task automatic send_event(input int k);
    logic [7:0] t [12];
    int n;
    t = TAB[k];
    @(negedge clk);
    bus_en = ENT[k];
    for (int i = 0; i < NB; i++) cur_tag[i] = ~t[i];
    put('1, '0);                     // R1: valid words without end-of-event
    for (int ph = 0; ph < 3; ph++) begin
      logic [NB-1:0] m;
      m = '0;
      for (int i = 0; i < NB; i++) begin
        m[i] = (i % 3 == ph);
        cur_tag[i] = ENT[k][i] ? t[i] : 8'hEE;   // R1: disabled buses carry junk
      end
      put(m, '1);                    // R1: end-of-event without valid elsewhere
    end
    n = 0;
    while (!done && n < 10) begin @(negedge clk); n++; end
    check("R2", $sformatf("vector %0d latency", k), n, 4);
    model(t, ENT[k]);
    check_result($sformatf("vector %0d", k));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) mcnt[i] = '0;
    merr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    check("R11", "reset done", done, 0);
    check("R11", "reset ref", ref_tag, 0);
    check("R11", "reset mismatch", mismatch, 0);
    check("R11", "reset loss", loss_cnt, 0);
    check("R11", "reset any_err", any_err, 0);

    for (int k = 0; k < NV; k++) send_event(k);

    // R1: a second end-of-event on bus 0 before the vote is ignored
    begin
      logic [7:0] t [12];
      for (int i = 0; i < NB; i++) begin t[i] = 8'h40; cur_tag[i] = 8'h40; end
      @(negedge clk); bus_en = '1;
      put(12'h001, 12'h001);
      cur_tag[0] = 8'h41;
      put(12'h001, 12'h001);
      put(12'hFFE, 12'hFFE);
      while (!done) @(negedge clk);
      model(t, 12'hFFF);
      check("R1", "duplicate ref", ref_tag, 8'h40);
      check_result("duplicate");
    end

    // R8: drive bus 3 and bus 7 past saturation
    for (int r = 0; r < 7; r++) send_event(1);
    check("R8", "bus3 saturated", loss_cnt[3*CN +: CN], 3'h7);

    // R10
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    check("R10", "clr loss", loss_cnt, 0);
    check("R10", "clr err_flags", err_flags, 0);
    check("R10", "clr any_err", any_err, 0);
    for (int i = 0; i < NB; i++) mcnt[i] = '0;
    merr = '0;
    send_event(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule